// File: doc/BRIEF.md
# Mask-Addressed GPIO Bank Register Block

This block holds the control state for one bank of general-purpose I/O lines behind a small memory-mapped bus made of a byte offset, a write strobe, write data and combinational read data. Each line has its own stored configuration word (function select, direction, pull resistors, filter, open-drain and input-trigger settings). That word is not reached through a private per-line address. Software first loads a line mask, and a single shared configuration address then writes every line whose mask bit is set. A read of that address returns the settings of one selected line.

Output values live in a latch per line that software changes through two write-one ports, one setting bits and one clearing them, and reads back through an output status word. Pad inputs pass through a two-stage synchronizer and are readable as a pin status word. The block drives the per-line output enable, output value, pull-up, pull-down, open-drain and function-select signals toward the pad ring. Successive banks are 0x40 bytes apart, so the block decodes only a 6-bit byte offset.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset the mask, every stored configuration and every output latch is zero, so all lines are GPIO inputs: pin_oe, pin_out, pin_pu, pin_pd, pin_od and pin_func are all zero and the output status word reads 0.
- R2: Byte offsets decode as mask 0x00, configuration 0x04, pin status 0x08, lock status 0x0C (reads 0), set-output 0x10, clear-output 0x14, output status 0x18. The set and clear offsets read 0, any other offset reads 0, and a write to an unused offset changes no state.
- R3: A write to offset 0x04 replaces the stored configuration of every line whose mask bit is 1 and leaves every other line unchanged.
- R4: Configuration word fields: bits [2:0] function (0 = GPIO, 1..7 = peripheral functions), bit 8 direction (1 = output), bit 9 pull-up, bit 10 pull-down, bit 12 input filter enable, bit 13 slow-clock filter select, bit 14 open-drain, bit 15 input trigger control. All other bits are not stored and read as 0.
- R5: A read of offset 0x04 returns the stored configuration of the lowest-numbered line whose mask bit is 1, and 0 when the mask is empty.
- R6: Writing offset 0x10 sets the output latch of every line whose data bit is 1; lines with a 0 bit keep their latch value.
- R7: Writing offset 0x14 clears the output latch of every line whose data bit is 1; lines with a 0 bit keep their latch value.
- R8: Offset 0x18 reads the current output latches of all lines, and pin_out equals those latches.
- R9: Offset 0x08 returns the pad inputs through two flops: a pad change made between clock edges is visible after the second following rising edge and not after the first.
- R10: When a line has both pull-up and pull-down stored, pin_pu is 1 and pin_pd is 0 for that line, while the configuration read still shows both bits.
- R11: Offset 0x00 reads back the last value written to the mask.
- R12: For each line n, pin_oe[n] is its direction bit, pin_od[n] its open-drain bit and pin_func[3n+2:3n] its function field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr, same cycle |
| pad_in | input | 32 | Asynchronous pad input levels |
| pin_oe | output | 32 | Per-line output enable |
| pin_out | output | 32 | Per-line output value |
| pin_pu | output | 32 | Per-line pull-up enable |
| pin_pd | output | 32 | Per-line pull-down enable, suppressed by pull-up |
| pin_od | output | 32 | Per-line open-drain enable |
| pin_func | output | 96 | Per-line 3-bit function select, line n at bits 3n+2..3n |

## Verification
Configuration writes are tried with a mask covering a contiguous group, a subset of that group, a single top line and an empty mask, which separates a write that reaches all lines, only the masked lines or the wrong line. Reads with masks holding several set bits, including line 31 together with low lines, distinguish lowest-line selection from highest-line or OR-combined readback. Walking a single bit through every configuration field and one unused bit pins each field position. Set and clear are driven with all-zero data as well as wide and narrow patterns, which separates write-one behaviour from plain overwrite, and pad changes are sampled one and two edges later to show the synchronizer depth.

// File: rtl/gmb_pkg.sv
package gmb_pkg;

  localparam int BUS_DW  = 32;
  localparam int BANK_AW = 6;
  localparam int FUNC_W  = 3;

  localparam logic [BANK_AW-1:0] OFS_MASK = 6'h00;
  localparam logic [BANK_AW-1:0] OFS_CFG  = 6'h04;
  localparam logic [BANK_AW-1:0] OFS_PDS  = 6'h08;
  localparam logic [BANK_AW-1:0] OFS_LOCK = 6'h0C;
  localparam logic [BANK_AW-1:0] OFS_SET  = 6'h10;
  localparam logic [BANK_AW-1:0] OFS_CLR  = 6'h14;
  localparam logic [BANK_AW-1:0] OFS_ODS  = 6'h18;

  localparam int B_FUNC_LO = 0;
  localparam int B_DIR     = 8;
  localparam int B_PU      = 9;
  localparam int B_PD      = 10;
  localparam int B_FILT    = 12;
  localparam int B_SLOW    = 13;
  localparam int B_OD      = 14;
  localparam int B_TRIG    = 15;

  typedef struct packed {
    logic              trig;
    logic              od;
    logic              slow;
    logic              filt;
    logic              pd;
    logic              pu;
    logic              dir;
    logic [FUNC_W-1:0] func;
  } line_cfg_t;

  function automatic line_cfg_t word_to_cfg(input logic [BUS_DW-1:0] w);
    line_cfg_t c;
    c.func = w[B_FUNC_LO +: FUNC_W];
    c.dir  = w[B_DIR];
    c.pu   = w[B_PU];
    c.pd   = w[B_PD];
    c.filt = w[B_FILT];
    c.slow = w[B_SLOW];
    c.od   = w[B_OD];
    c.trig = w[B_TRIG];
    return c;
  endfunction

  function automatic logic [BUS_DW-1:0] cfg_to_word(input line_cfg_t c);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[B_FUNC_LO +: FUNC_W] = c.func;
    w[B_DIR]  = c.dir;
    w[B_PU]   = c.pu;
    w[B_PD]   = c.pd;
    w[B_FILT] = c.filt;
    w[B_SLOW] = c.slow;
    w[B_OD]   = c.od;
    w[B_TRIG] = c.trig;
    return w;
  endfunction

endpackage

// File: rtl/gmb_rst_sync.sv
module gmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/gmb_pad_sync.sv
module gmb_pad_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_async,
  output logic [N-1:0] pad_q
);
  logic [N-1:0] meta_q;
  logic [N-1:0] meta_d;
  logic [N-1:0] pad_d;

  always_comb begin
    meta_d = pad_async;
    pad_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      pad_q  <= '0;
    end else begin
      meta_q <= meta_d;
      pad_q  <= pad_d;
    end
  end
endmodule

// File: rtl/gmb_cfg_store.sv
module gmb_cfg_store #(
  parameter int N = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [N-1:0]                  line_sel,
  input  gmb_pkg::line_cfg_t            cfg_wr,
  output gmb_pkg::line_cfg_t [N-1:0]    cfg_q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic               upd_en;
    gmb_pkg::line_cfg_t cfg_d;

    always_comb begin
      upd_en = cfg_we & line_sel[g];
      cfg_d  = cfg_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (upd_en) cfg_q[g] <= cfg_d;
    end

    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !line_sel[g]) |=> $stable(cfg_q[g])) else $error("unselected line changed"); // R3
    AST_SELECTED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && line_sel[g]) |=> (cfg_q[g] == $past(cfg_wr))) else $error("selected line not loaded"); // R3
  end
endmodule

// File: rtl/gmb_out_latch.sv
module gmb_out_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [N-1:0] set_bits,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] lat_q
);
  logic         lat_en;
  logic [N-1:0] lat_d;

  always_comb begin
    lat_en = set_we | clr_we;
    lat_d  = lat_q;
    if (set_we) lat_d = lat_d | set_bits;
    if (clr_we) lat_d = lat_d & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((lat_q & $past(set_bits)) == $past(set_bits))) else $error("set bit not high"); // R6
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((lat_q & ~$past(set_bits)) == ($past(lat_q) & ~$past(set_bits)))) else $error("set touched zero bit"); // R6
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((lat_q & $past(clr_bits)) == '0)) else $error("clear bit not low"); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(lat_q)) else $error("latch moved without write"); // R8
endmodule

// File: rtl/gmb_low_pick.sv
module gmb_low_pick #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     sel,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic below_set;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    below_set = 1'b0;
    for (int j = 0; j < N; j++) begin
      if ((IDX_W'(j) < idx) && sel[j]) below_set = 1'b1;
    end
    if (hit) begin
      AST_PICK_IS_SET: assert (sel[idx]) else $error("picked line not in mask"); // R5
      AST_PICK_IS_LOWEST: assert (!below_set) else $error("lower line skipped"); // R5
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int NLINES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [gmb_pkg::BANK_AW-1:0]   bus_addr,
  input  logic                          bus_we,
  input  logic [gmb_pkg::BUS_DW-1:0]    bus_wdata,
  output logic [gmb_pkg::BUS_DW-1:0]    bus_rdata,
  input  logic [NLINES-1:0]             pad_in,
  output logic [NLINES-1:0]             pin_oe,
  output logic [NLINES-1:0]             pin_out,
  output logic [NLINES-1:0]             pin_pu,
  output logic [NLINES-1:0]             pin_pd,
  output logic [NLINES-1:0]             pin_od,
  output logic [NLINES*gmb_pkg::FUNC_W-1:0] pin_func
);
  import gmb_pkg::*;

  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic                    rst_q_n;
  logic [NLINES-1:0]       mask_q;
  logic [NLINES-1:0]       mask_d;
  logic                    mask_en;
  logic                    cfg_we;
  logic                    set_we;
  logic                    clr_we;
  line_cfg_t               cfg_wr;
  line_cfg_t [NLINES-1:0]  cfg_q;
  logic [NLINES-1:0]       lat_q;
  logic [NLINES-1:0]       pad_q;
  logic                    pick_hit;
  logic [IDX_W-1:0]        pick_idx;
  logic [BUS_DW-1:0]       rd_d;

  gmb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  // write decode
  always_comb begin
    mask_en = bus_we && (bus_addr == OFS_MASK);
    cfg_we  = bus_we && (bus_addr == OFS_CFG);
    set_we  = bus_we && (bus_addr == OFS_SET);
    clr_we  = bus_we && (bus_addr == OFS_CLR);
    mask_d  = bus_wdata[NLINES-1:0];
    cfg_wr  = word_to_cfg(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  gmb_cfg_store #(.N(NLINES)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .line_sel(mask_q),
    .cfg_wr(cfg_wr), .cfg_q(cfg_q)
  );

  gmb_out_latch #(.N(NLINES)) u_lat (
    .clk(clk), .rst_n(rst_q_n),
    .set_we(set_we), .set_bits(bus_wdata[NLINES-1:0]),
    .clr_we(clr_we), .clr_bits(bus_wdata[NLINES-1:0]),
    .lat_q(lat_q)
  );

  gmb_pad_sync #(.N(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .pad_async(pad_in), .pad_q(pad_q)
  );

  gmb_low_pick #(.N(NLINES), .IDX_W(IDX_W)) u_pick (
    .sel(mask_q), .hit(pick_hit), .idx(pick_idx)
  );

  // read mux
  always_comb begin
    rd_d = '0;
    case (bus_addr)
      OFS_MASK: rd_d[NLINES-1:0] = mask_q;
      OFS_CFG:  rd_d = pick_hit ? cfg_to_word(cfg_q[pick_idx]) : '0;
      OFS_PDS:  rd_d[NLINES-1:0] = pad_q;
      OFS_ODS:  rd_d[NLINES-1:0] = lat_q;
      default:  rd_d = '0;
    endcase
  end

  assign bus_rdata = rd_d;

  // pad-side drive
  for (genvar g = 0; g < NLINES; g++) begin : g_pin
    assign pin_oe[g] = cfg_q[g].dir;
    assign pin_pu[g] = cfg_q[g].pu;
    assign pin_pd[g] = cfg_q[g].pd & ~cfg_q[g].pu;
    assign pin_od[g] = cfg_q[g].od;
    assign pin_func[g*FUNC_W +: FUNC_W] = cfg_q[g].func;
  end
  assign pin_out = lat_q;

  AST_EMPTY_MASK_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((bus_addr == OFS_CFG) && (mask_q == '0)) |-> (bus_rdata == '0)) else $error("empty-mask read not zero"); // R5
  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && (bus_addr == OFS_MASK)) |=> (mask_q == $past(bus_wdata[NLINES-1:0]))) else $error("mask not loaded"); // R11
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(bus_we && (bus_addr == OFS_MASK)) |=> $stable(mask_q)) else $error("mask changed"); // R2
endmodule

// File: tb/gpio_mask_bank_bench.sv
module gpio_mask_bank_bench;
  logic        clk;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pin_oe, pin_out, pin_pu, pin_pd, pin_od;
  logic [95:0] pin_func;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_cfg [32];
  logic [31:0] exp_lat;
  localparam logic [31:0] KEEP = 32'h0000_F707;

  gpio_mask_bank u_gpio_mask_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .pin_pd(pin_pd),
    .pin_od(pin_od), .pin_func(pin_func)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  // model: configuration write on masked lines
  task automatic cfg_write(input logic [31:0] m, input logic [31:0] d);
    bwr(6'h00, m);
    bwr(6'h04, d);
    for (int i = 0; i < 32; i++) if (m[i]) exp_cfg[i] = d & KEEP;
  endtask

  task automatic check_pins(input string tag);
    logic [31:0] eoe, epu, epd, eod;
    logic [95:0] efn;
    for (int i = 0; i < 32; i++) begin
      eoe[i] = exp_cfg[i][8];
      epu[i] = exp_cfg[i][9];
      epd[i] = exp_cfg[i][10] & ~exp_cfg[i][9];
      eod[i] = exp_cfg[i][14];
      efn[i*3 +: 3] = exp_cfg[i][2:0];
    end
    @(negedge clk); #1;
    chk({tag, " pin_oe"}, pin_oe, eoe);
    chk({tag, " pin_pu"}, pin_pu, epu);
    chk({tag, " pin_pd"}, pin_pd, epd);
    chk({tag, " pin_od"}, pin_od, eod);
    chk({tag, " pin_func lo"}, pin_func[31:0], efn[31:0]);
    chk({tag, " pin_func mid"}, pin_func[63:32], efn[63:32]);
    chk({tag, " pin_func hi"}, pin_func[95:64], efn[95:64]);
    chk({tag, " pin_out"}, pin_out, exp_lat);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    brd(6'h00, r); chk("R1 mask after reset", r, 32'h0);
    brd(6'h04, r); chk("R1 cfg after reset", r, 32'h0);
    brd(6'h18, r); chk("R1 output status after reset", r, 32'h0);
    check_pins("R1 reset");
  endtask

  task automatic t_mask;
    logic [31:0] r;
    bwr(6'h00, 32'hA5A5_0F0F); brd(6'h00, r); chk("R11 mask readback a", r, 32'hA5A5_0F0F);
    bwr(6'h00, 32'h8000_0001); brd(6'h00, r); chk("R11 mask readback b", r, 32'h8000_0001);
  endtask

  task automatic t_masked_write;
    logic [31:0] r;
    cfg_write(32'h0000_00F0, 32'hFFFF_FFFF);
    check_pins("R3 R12 group write");
    brd(6'h04, r); chk("R4 all fields readback", r, 32'h0000_F707);
    cfg_write(32'h0000_0030, 32'h0000_0102);
    check_pins("R3 R12 subset write");
    bwr(6'h00, 32'h0000_0040); brd(6'h04, r); chk("R3 unmasked line 6 kept", r, 32'h0000_F707);
    bwr(6'h00, 32'h0000_0020); brd(6'h04, r); chk("R3 masked line 5 loaded", r, 32'h0000_0102);
  endtask

  task automatic t_fields;
    logic [31:0] r;
    int bits [12] = '{0, 1, 2, 8, 9, 10, 11, 12, 13, 14, 15, 20};
    for (int k = 0; k < 12; k++) begin
      cfg_write(32'h8000_0000, 32'h1 << bits[k]);
      brd(6'h04, r);
      chk($sformatf("R4 field bit %0d", bits[k]), r, (32'h1 << bits[k]) & KEEP);
    end
    cfg_write(32'h8000_0000, 32'h0000_4105);
    check_pins("R12 line 31 fields");
  endtask

  task automatic t_lowest;
    logic [31:0] r;
    bwr(6'h00, 32'h8000_0030); brd(6'h04, r); chk("R5 lowest of 4,5,31", r, exp_cfg[4]);
    bwr(6'h00, 32'h8000_0000); brd(6'h04, r); chk("R5 only line 31", r, exp_cfg[31]);
    bwr(6'h00, 32'h8000_0040); brd(6'h04, r); chk("R5 lowest of 6,31", r, exp_cfg[6]);
    bwr(6'h00, 32'h0000_0000); brd(6'h04, r); chk("R5 empty mask", r, 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] r;
    bwr(6'h10, 32'h0000_FFFF); exp_lat = 32'h0000_FFFF;
    brd(6'h18, r); chk("R6 R8 set wide", r, exp_lat);
    bwr(6'h10, 32'h0); brd(6'h18, r); chk("R6 zero set no effect", r, exp_lat);
    bwr(6'h14, 32'h0000_00F0); exp_lat = 32'h0000_FF0F;
    brd(6'h18, r); chk("R7 clear narrow", r, exp_lat);
    bwr(6'h14, 32'h0); brd(6'h18, r); chk("R7 zero clear no effect", r, exp_lat);
    bwr(6'h10, 32'hF000_0000); exp_lat = 32'hF000_FF0F;
    brd(6'h18, r); chk("R6 set high lines", r, exp_lat);
    check_pins("R8 pin_out");
  endtask

  task automatic t_pad;
    logic [31:0] pats [2] = '{32'h1234_5678, 32'hFEDC_0001};
    logic [31:0] prev;
    prev = 32'h0;
    bus_addr = 6'h08;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); pad_in = pats[k];
      #1 chk("R9 pad no edge yet", bus_rdata, prev);
      @(negedge clk); #1 chk("R9 pad after one edge", bus_rdata, prev);
      @(negedge clk); #1 chk("R9 pad after two edges", bus_rdata, pats[k]);
      prev = pats[k];
    end
  endtask

  task automatic t_pull;
    logic [31:0] r;
    cfg_write(32'h0000_0200, 32'h0000_0600);
    check_pins("R10 both pulls");
    brd(6'h04, r); chk("R10 readback both pulls", r, 32'h0000_0600);
    cfg_write(32'h0000_0200, 32'h0000_0400);
    check_pins("R10 pull-down alone");
  endtask

  task automatic t_map;
    logic [31:0] r;
    logic [5:0] rz [5] = '{6'h0C, 6'h10, 6'h14, 6'h1C, 6'h3C};
    bwr(6'h00, 32'h0000_0200);
    for (int k = 0; k < 5; k++) begin
      brd(rz[k], r); chk($sformatf("R2 read of %h", rz[k]), r, 32'h0);
    end
    bwr(6'h20, 32'hFFFF_FFFF);
    bwr(6'h3C, 32'hFFFF_FFFF);
    brd(6'h00, r); chk("R2 mask untouched by unused write", r, 32'h0000_0200);
    brd(6'h18, r); chk("R2 latch untouched by unused write", r, exp_lat);
    brd(6'h04, r); chk("R2 cfg untouched by unused write", r, exp_cfg[9]);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    exp_lat = '0;
    for (int i = 0; i < 32; i++) exp_cfg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_mask;
    t_masked_write;
    t_fields;
    t_lowest;
    t_set_clear;
    t_pad;
    t_pull;
    t_map;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule